// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles conditional branches while they sit in the decode stage of a five-stage in-order pipeline, one stage earlier than an ALU-based resolution would. It owns a small comparator that checks either two registers against each other or one register against zero. Its two comparator operands get their own forwarding path from the later pipeline registers, and hazard logic holds decode when an operand has not been produced yet.

Fetch is assumed to follow static predict-taken: the instruction fetched after a branch comes from the branch target. A branch that turns out taken needs nothing further. A branch that falls through is a misprediction: the block asks fetch to restart at the fall-through address. When branch delay slots are off, it also asks for the wrong-path instruction to be killed. When delay slots are on, the instruction right after the branch is kept, and fetch restarts one instruction further on. The delay-slot setting is a quasi-static configuration input, captured in a register.

The compare, forwarding and stall decisions are combinational, so the surrounding pipeline can act on them in the same cycle the branch is in decode. Only the delay-slot mode is held in a flop.

Top module: `br_resolve_id`

## Requirements
- R1: A synchronous reset clears the delay-slot mode to disabled, so the first not-taken branch after reset redirects to pc+4 and requests a flush, whatever the configuration input held during reset.
- R2: Branch kind code 1 is taken when both operands are equal, and code 2 is taken when they differ.
- R3: Kind code 3 is taken when operand A is zero, and code 4 is taken when operand A is non-zero. For these kinds the B source register is ignored: it neither stalls nor affects the outcome.
- R4: A resolved branch whose condition holds raises br_taken and raises neither redirect_req nor flush_req.
- R5: A resolved branch whose condition fails while delay-slot mode is off raises redirect_req with redirect_pc equal to pc+4, and raises flush_req.
- R6: A resolved branch whose condition fails while delay-slot mode is on raises redirect_req with redirect_pc equal to pc+8, and keeps flush_req low.
- R7: Each operand takes its value in this priority order:
  - the EX/MEM result, when that stage writes the source register and is not a load;
  - the MEM/WB value, when that stage writes the source register;
  - the register-file value.
- R8: stall_req is raised when a used source register is written by the instruction in ID/EX, whether that instruction is an ALU operation or a load. It is also raised when a used source register is written by a load in EX/MEM. As the load advances, a load in ID/EX therefore stalls decode for two cycles and an ALU operation for one.
- R9: While stall_req is high, br_taken, redirect_req and flush_req are all low.
- R10: Source register 0 always reads as zero and never matches a forwarding source or a hazard.
- R11: The delay-slot mode takes the value of slot_cfg_in one clock after it is applied.
- R12: When id_valid is low, or the kind code is 0 or above 4, all of br_taken, redirect_req, flush_req and stall_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_cfg_in | input | 1 | Delay-slot enable configuration |
| id_valid | input | 1 | Decode stage holds a valid instruction |
| id_kind | input | 3 | Branch kind: 0 none, 1 equal, 2 not equal, 3 zero, 4 non-zero |
| id_src_a | input | REG_W | First source register number |
| id_src_b | input | REG_W | Second source register number |
| id_pc | input | XLEN | Address of the branch in decode |
| rf_val_a | input | XLEN | Register-file read of source A |
| rf_val_b | input | XLEN | Register-file read of source B |
| idex_wr_en | input | 1 | ID/EX instruction writes a register |
| idex_dst | input | REG_W | ID/EX destination register |
| exm_wr_en | input | 1 | EX/MEM instruction writes a register |
| exm_dst | input | REG_W | EX/MEM destination register |
| exm_is_load | input | 1 | EX/MEM instruction is a load |
| exm_result | input | XLEN | EX/MEM ALU result |
| mwb_wr_en | input | 1 | MEM/WB instruction writes a register |
| mwb_dst | input | REG_W | MEM/WB destination register |
| mwb_value | input | XLEN | MEM/WB write-back value |
| br_taken | output | 1 | Branch resolved taken |
| redirect_req | output | 1 | Restart fetch at redirect_pc |
| redirect_pc | output | XLEN | Fall-through restart address |
| flush_req | output | 1 | Kill the wrong-path instruction behind the branch |
| stall_req | output | 1 | Hold decode this cycle |

## Verification
The hardest case to reach is a load-to-branch dependency seen across successive cycles. The load must first sit in ID/EX and then in EX/MEM, its value must then arrive through MEM/WB, and a stale register-file value must be present that would give a different outcome. The bench steps the pipeline-register inputs through that sequence by hand, one clock at a time. A second directed case sets the EX/MEM result, the MEM/WB value and the register-file value to different numbers for the same register, so that the priority order decides the branch. Long random stretches then draw register numbers from a range of four and values from a range of three, so that matches, equal values and zero values occur often.

// File: rtl/br_res_pkg.sv
package br_res_pkg;

  typedef enum logic [2:0] {
    BRK_NONE = 3'd0,
    BRK_EQ   = 3'd1,
    BRK_NE   = 3'd2,
    BRK_EZ   = 3'd3,
    BRK_NZ   = 3'd4
  } br_kind_e;

  function automatic logic kind_is_branch(input logic [2:0] k);
    return (k == BRK_EQ) || (k == BRK_NE) || (k == BRK_EZ) || (k == BRK_NZ);
  endfunction

  function automatic logic kind_uses_b(input logic [2:0] k);
    return (k == BRK_EQ) || (k == BRK_NE);
  endfunction

endpackage

// File: rtl/br_opnd_fwd.sv
module br_opnd_fwd #(
  parameter int XLEN  = 32,
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [XLEN-1:0]  rf_val,
  input  logic             exm_wr_en,
  input  logic [REG_W-1:0] exm_dst,
  input  logic             exm_is_load,
  input  logic [XLEN-1:0]  exm_result,
  input  logic             mwb_wr_en,
  input  logic [REG_W-1:0] mwb_dst,
  input  logic [XLEN-1:0]  mwb_value,
  output logic [XLEN-1:0]  opnd
);

  logic src_nz;
  logic exm_hit;
  logic mwb_hit;

  assign src_nz  = (src != '0);
  assign exm_hit = src_nz && exm_wr_en && !exm_is_load && (exm_dst == src);
  assign mwb_hit = src_nz && mwb_wr_en && (mwb_dst == src);

  always_comb begin
    if (!src_nz)      opnd = '0;
    else if (exm_hit) opnd = exm_result;
    else if (mwb_hit) opnd = mwb_value;
    else              opnd = rf_val;
  end

endmodule

// File: rtl/br_hazard.sv
module br_hazard
  import br_res_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             id_valid,
  input  logic [2:0]       id_kind,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic             idex_wr_en,
  input  logic [REG_W-1:0] idex_dst,
  input  logic             exm_wr_en,
  input  logic [REG_W-1:0] exm_dst,
  input  logic             exm_is_load,
  output logic             stall
);

  function automatic logic pending(input logic [REG_W-1:0] s,
                                   input logic             iw,
                                   input logic [REG_W-1:0] id,
                                   input logic             ew,
                                   input logic [REG_W-1:0] ed,
                                   input logic             el);
    logic near_hit;
    logic load_hit;
    near_hit = iw && (id == s);
    load_hit = ew && el && (ed == s);
    return (s != '0) && (near_hit || load_hit);
  endfunction

  logic use_a;
  logic use_b;
  logic wait_a;
  logic wait_b;

  assign use_a  = id_valid && kind_is_branch(id_kind);
  assign use_b  = id_valid && kind_uses_b(id_kind);
  assign wait_a = pending(id_src_a, idex_wr_en, idex_dst, exm_wr_en, exm_dst, exm_is_load);
  assign wait_b = pending(id_src_b, idex_wr_en, idex_dst, exm_wr_en, exm_dst, exm_is_load);
  assign stall  = (use_a && wait_a) || (use_b && wait_b);

endmodule

// File: rtl/br_cmp.sv
module br_cmp
  import br_res_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2:0]      kind,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  output logic            cond
);

  logic same;
  logic a_zero;

  assign same   = (op_a == op_b);
  assign a_zero = (op_a == '0);

  always_comb begin
    unique case (kind)
      BRK_EQ:  cond = same;
      BRK_NE:  cond = !same;
      BRK_EZ:  cond = a_zero;
      BRK_NZ:  cond = !a_zero;
      default: cond = 1'b0;
    endcase
  end

endmodule

// File: rtl/br_resolve_id.sv
module br_resolve_id
  import br_res_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int REG_W      = 5,
  parameter int INSN_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slot_cfg_in,
  input  logic             id_valid,
  input  logic [2:0]       id_kind,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic [XLEN-1:0]  id_pc,
  input  logic [XLEN-1:0]  rf_val_a,
  input  logic [XLEN-1:0]  rf_val_b,
  input  logic             idex_wr_en,
  input  logic [REG_W-1:0] idex_dst,
  input  logic             exm_wr_en,
  input  logic [REG_W-1:0] exm_dst,
  input  logic             exm_is_load,
  input  logic [XLEN-1:0]  exm_result,
  input  logic             mwb_wr_en,
  input  logic [REG_W-1:0] mwb_dst,
  input  logic [XLEN-1:0]  mwb_value,
  output logic             br_taken,
  output logic             redirect_req,
  output logic [XLEN-1:0]  redirect_pc,
  output logic             flush_req,
  output logic             stall_req
);

  localparam int NUM_SRC = 2;
  localparam logic [XLEN-1:0] STEP_ONE = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] STEP_TWO = XLEN'(2 * INSN_BYTES);

  logic             slot_mode_q;
  logic [REG_W-1:0] src_num [NUM_SRC];
  logic [XLEN-1:0]  src_rf  [NUM_SRC];
  logic [XLEN-1:0]  opnd    [NUM_SRC];
  logic             stall_w;
  logic             cond_w;
  logic             resolve;

  always_ff @(posedge clk) begin
    if (rst) slot_mode_q <= 1'b0;
    else     slot_mode_q <= slot_cfg_in;
  end

  assign src_num[0] = id_src_a;
  assign src_num[1] = id_src_b;
  assign src_rf[0]  = rf_val_a;
  assign src_rf[1]  = rf_val_b;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_fwd
    br_opnd_fwd #(.XLEN(XLEN), .REG_W(REG_W)) u_fwd (
      .src         (src_num[g]),
      .rf_val      (src_rf[g]),
      .exm_wr_en   (exm_wr_en),
      .exm_dst     (exm_dst),
      .exm_is_load (exm_is_load),
      .exm_result  (exm_result),
      .mwb_wr_en   (mwb_wr_en),
      .mwb_dst     (mwb_dst),
      .mwb_value   (mwb_value),
      .opnd        (opnd[g])
    );
  end

  br_hazard #(.REG_W(REG_W)) u_haz (
    .id_valid    (id_valid),
    .id_kind     (id_kind),
    .id_src_a    (id_src_a),
    .id_src_b    (id_src_b),
    .idex_wr_en  (idex_wr_en),
    .idex_dst    (idex_dst),
    .exm_wr_en   (exm_wr_en),
    .exm_dst     (exm_dst),
    .exm_is_load (exm_is_load),
    .stall       (stall_w)
  );

  br_cmp #(.XLEN(XLEN)) u_cmp (
    .kind (id_kind),
    .op_a (opnd[0]),
    .op_b (opnd[1]),
    .cond (cond_w)
  );

  assign resolve      = id_valid && kind_is_branch(id_kind) && !stall_w;
  assign stall_req    = stall_w;
  assign br_taken     = resolve && cond_w;
  assign redirect_req = resolve && !cond_w;
  assign flush_req    = resolve && !cond_w && !slot_mode_q;
  assign redirect_pc  = id_pc + (slot_mode_q ? STEP_TWO : STEP_ONE);

endmodule

// File: rtl/br_resolve_chk.sv
module br_resolve_chk
  import br_res_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int REG_W      = 5,
  parameter int INSN_BYTES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             id_valid,
  input logic [2:0]       id_kind,
  input logic [REG_W-1:0] id_src_a,
  input logic [REG_W-1:0] id_src_b,
  input logic [XLEN-1:0]  id_pc,
  input logic             idex_wr_en,
  input logic [REG_W-1:0] idex_dst,
  input logic             exm_wr_en,
  input logic [REG_W-1:0] exm_dst,
  input logic             exm_is_load,
  input logic [XLEN-1:0]  exm_result,
  input logic             br_taken,
  input logic             redirect_req,
  input logic [XLEN-1:0]  redirect_pc,
  input logic             flush_req,
  input logic             stall_req
);

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    stall_req |-> (!br_taken && !redirect_req && !flush_req)); // R9

  AST_TAKEN_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> (!redirect_req && !flush_req)); // R4

  AST_FLUSH_WITH_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> (redirect_req && redirect_pc == id_pc + XLEN'(INSN_BYTES))); // R5

  AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (rst)
    (redirect_req && !flush_req) |-> (redirect_pc == id_pc + XLEN'(2 * INSN_BYTES))); // R6

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (!id_valid || !kind_is_branch(id_kind)) |->
      (!stall_req && !br_taken && !redirect_req && !flush_req)); // R12

  AST_ZERO_SRC_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (id_src_a == '0 && (id_src_b == '0 || !kind_uses_b(id_kind))) |-> !stall_req); // R10

  AST_NEAR_WRITER_STALLS: assert property (@(posedge clk) disable iff (rst)
    (id_valid && kind_is_branch(id_kind) && idex_wr_en && idex_dst != '0 &&
     idex_dst == id_src_a) |-> stall_req); // R8

  AST_EXM_FORWARD_WINS: assert property (@(posedge clk) disable iff (rst)
    (id_valid && id_kind == BRK_EZ && !stall_req && exm_wr_en && !exm_is_load &&
     exm_dst != '0 && exm_dst == id_src_a && exm_result == '0) |-> br_taken); // R7

endmodule

bind br_resolve_id br_resolve_chk #(
  .XLEN(XLEN), .REG_W(REG_W), .INSN_BYTES(INSN_BYTES)
) u_chk (.*);

// File: tb/test_br_resolve_id.sv
module test_br_resolve_id;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slot_cfg_in = 1'b0;
  logic        id_valid = 1'b0;
  logic [2:0]  id_kind = 3'd0;
  logic [4:0]  id_src_a = '0, id_src_b = '0;
  logic [31:0] id_pc = '0, rf_val_a = '0, rf_val_b = '0;
  logic        idex_wr_en = 1'b0;
  logic [4:0]  idex_dst = '0;
  logic        exm_wr_en = 1'b0, exm_is_load = 1'b0;
  logic [4:0]  exm_dst = '0;
  logic [31:0] exm_result = '0;
  logic        mwb_wr_en = 1'b0;
  logic [4:0]  mwb_dst = '0;
  logic [31:0] mwb_value = '0;
  logic        br_taken, redirect_req, flush_req, stall_req;
  logic [31:0] redirect_pc;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    checking = 1'b0;
  bit    done = 1'b0;
  bit    exp_slot = 1'b0;
  string phase = "R1 R11 reset";

  always #10 clk = ~clk;

  br_resolve_id i_br_resolve_id (
    .clk(clk), .rst(rst), .slot_cfg_in(slot_cfg_in), .id_valid(id_valid),
    .id_kind(id_kind), .id_src_a(id_src_a), .id_src_b(id_src_b), .id_pc(id_pc),
    .rf_val_a(rf_val_a), .rf_val_b(rf_val_b), .idex_wr_en(idex_wr_en),
    .idex_dst(idex_dst), .exm_wr_en(exm_wr_en), .exm_dst(exm_dst),
    .exm_is_load(exm_is_load), .exm_result(exm_result), .mwb_wr_en(mwb_wr_en),
    .mwb_dst(mwb_dst), .mwb_value(mwb_value), .br_taken(br_taken),
    .redirect_req(redirect_req), .redirect_pc(redirect_pc), .flush_req(flush_req),
    .stall_req(stall_req)
  );

  // Reference mode flop: R1 clears it, R11 follows the config one clock later
  always @(posedge clk) exp_slot <= rst ? 1'b0 : slot_cfg_in;

  function automatic logic [31:0] value_of(input logic [4:0] r, input logic [31:0] rf);
    if (r == 0) return 0;                                                 // R10
    if (exm_wr_en && !exm_is_load && exm_dst == r) return exm_result;     // R7
    if (mwb_wr_en && mwb_dst == r) return mwb_value;
    return rf;
  endfunction

  function automatic bit waiting(input logic [4:0] r);
    if (r == 0) return 0;
    return (idex_wr_en && idex_dst == r) || (exm_wr_en && exm_is_load && exm_dst == r);
  endfunction

  task automatic cmp1(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking && !rst) begin
      int  k;
      bit  is_br, two, stl, cnd, res;
      logic [31:0] va, vb;
      k     = int'(id_kind);
      is_br = id_valid && k >= 1 && k <= 4;
      two   = (k == 1) || (k == 2);
      va    = value_of(id_src_a, rf_val_a);
      vb    = value_of(id_src_b, rf_val_b);
      stl   = is_br && (waiting(id_src_a) || (two && waiting(id_src_b)));
      case (k)
        1: cnd = (va == vb);
        2: cnd = (va != vb);
        3: cnd = (va == 0);
        4: cnd = (va != 0);
        default: cnd = 0;
      endcase
      res = is_br && !stl;
      cmp1("stall_req", 32'(stall_req), 32'(stl));
      cmp1("br_taken", 32'(br_taken), 32'(res && cnd));
      cmp1("redirect_req", 32'(redirect_req), 32'(res && !cnd));
      cmp1("flush_req", 32'(flush_req), 32'(res && !cnd && !exp_slot));
      if (res && !cnd)
        cmp1("redirect_pc", redirect_pc, id_pc + (exp_slot ? 32'd8 : 32'd4));
    end
  end

  task automatic quiet_pipe();
    idex_wr_en = 0; idex_dst = 0;
    exm_wr_en = 0; exm_dst = 0; exm_is_load = 0; exm_result = 0;
    mwb_wr_en = 0; mwb_dst = 0; mwb_value = 0;
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    slot_cfg_in = 1;
    repeat (3) step();
    // R1: first cycle after reset, mode still off despite config high
    rst = 0; checking = 1;
    id_valid = 1; id_kind = 3'd1; id_src_a = 5'd1; id_src_b = 5'd2;
    rf_val_a = 32'd1; rf_val_b = 32'd2; id_pc = 32'h100;
    step();
    // R11 R6: mode now on, not-taken goes to pc+8 without flush
    phase = "R6 R11 slot on";
    step();
    slot_cfg_in = 0;
    step();
    phase = "R5 slot off";
    step();

    // R7: three candidate values for the same register
    phase = "R7 priority";
    id_kind = 3'd1; id_src_a = 5'd5; id_src_b = 5'd6; rf_val_b = 32'd7;
    rf_val_a = 32'd11; exm_wr_en = 1; exm_dst = 5'd5; exm_result = 32'd7;
    mwb_wr_en = 1; mwb_dst = 5'd5; mwb_value = 32'd9;
    step();
    exm_wr_en = 0; rf_val_b = 32'd9;
    step();
    mwb_wr_en = 0; rf_val_b = 32'd11;
    step();

    // R8 R9: load feeding a zero-test branch, advanced by hand
    phase = "R8 R9 load sequence";
    quiet_pipe(); id_kind = 3'd3; id_src_a = 5'd4; rf_val_a = 32'd0;
    idex_wr_en = 1; idex_dst = 5'd4;
    step();
    quiet_pipe(); exm_wr_en = 1; exm_is_load = 1; exm_dst = 5'd4;
    step();
    quiet_pipe(); mwb_wr_en = 1; mwb_dst = 5'd4; mwb_value = 32'd3;
    step();
    quiet_pipe(); idex_wr_en = 1; idex_dst = 5'd4; exm_is_load = 0;
    id_kind = 3'd2; id_src_b = 5'd4;
    step();

    // R10: register zero never forwards or stalls
    phase = "R10 zero reg";
    quiet_pipe(); id_kind = 3'd3; id_src_a = 5'd0; rf_val_a = 32'd5;
    idex_wr_en = 1; idex_dst = 5'd0; exm_wr_en = 1; exm_dst = 5'd0; exm_result = 32'd5;
    step();

    // R3: B register ignored for single-operand kinds
    phase = "R3 single operand";
    quiet_pipe(); id_kind = 3'd4; id_src_a = 5'd2; rf_val_a = 32'd6;
    id_src_b = 5'd3; idex_wr_en = 1; idex_dst = 5'd3;
    step();
    id_kind = 3'd3;
    step();

    // R12: not a branch, no reaction even with hazards present
    phase = "R12 idle";
    id_valid = 0; idex_dst = 5'd2;
    step();
    id_valid = 1; id_kind = 3'd6;
    step();

    phase = "R2 R4 R5 R6 random";
    for (int i = 0; i < 4000; i++) begin
      if ((i % 97) == 0) slot_cfg_in = $urandom_range(0, 1);
      id_valid = ($urandom_range(0, 9) != 0);
      id_kind = 3'($urandom_range(0, 6));
      id_src_a = 5'($urandom_range(0, 3)); id_src_b = 5'($urandom_range(0, 3));
      id_pc = {$urandom, 2'b00} ;
      rf_val_a = $urandom_range(0, 2); rf_val_b = $urandom_range(0, 2);
      idex_wr_en = $urandom_range(0, 1); idex_dst = 5'($urandom_range(0, 3));
      exm_wr_en = $urandom_range(0, 1); exm_dst = 5'($urandom_range(0, 3));
      exm_is_load = $urandom_range(0, 1); exm_result = $urandom_range(0, 2);
      mwb_wr_en = $urandom_range(0, 1); mwb_dst = 5'($urandom_range(0, 3));
      mwb_value = $urandom_range(0, 2);
      step();
    end

    @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule